// File: doc/BRIEF.md
# Per-Pin Input Debouncer with Edge Event Generation

This block cleans up one slow input pin, such as a button or a mechanical switch, whose level has already been synchronized to the system clock. A sampling tick, generated elsewhere and nominally once per millisecond, decides when the raw level is examined. The block keeps a filtered stable level. It moves that level only after the raw input has disagreed with it on a programmed number of consecutive ticks. The rising direction and the falling direction each have their own count.

Every accepted transition can raise a one-cycle event for an interrupt controller. The event fires for the active direction only, which is set by an active-low polarity control. In dual-edge mode it fires for both directions. The block also keeps an edge-sense flag that follows the level the filter expects to leave next, and flips it on every acceptance. Software-visible reads use a polarity-corrected copy of the stable level. When the block is enabled, it takes its stable level from the first raw sample, so no spurious event is produced on start-up.

Top module: `pin_debounce_filter`

## Requirements
- R1: While `rst` is high, on the following clock edge `stable_q`, `read_q`, `event_q` and `sense_q` all become 0.
- R2: In the first cycle `en` is high after reset or after a cycle with `en` low, the block copies `raw_in` into `stable_q` and `sense_q` at that clock edge, with or without `tick`, and raises no event.
- R3: A tick on which `raw_in` equals `stable_q` restores the full count, so disagreeing ticks that are separated by an agreeing tick never cause acceptance.
- R4: With `stable_q` at 0, the level changes to 1 at the clock edge of the RISE_TICKS-th consecutive tick that samples `raw_in` = 1. Cycles without `tick` neither advance nor break the run.
- R5: With `stable_q` at 1, the level changes to 0 at the clock edge of the FALL_TICKS-th consecutive tick that samples `raw_in` = 0.
- R6: With `pol_low` = 0 and `dual_edge` = 0, an accepted 0-to-1 transition raises `event_q`, and an accepted 1-to-0 transition does not.
- R7: With `pol_low` = 1 and `dual_edge` = 0, an accepted 1-to-0 transition raises `event_q`, and an accepted 0-to-1 transition does not.
- R8: With `dual_edge` = 1, every accepted transition raises `event_q`, whatever `pol_low` is.
- R9: `event_q` is high for exactly the one cycle after the clock edge of the accepting tick, and never without a tick in the cycle before.
- R10: `sense_q` inverts on every accepted transition.
- R11: After every clock edge out of reset, `read_q` equals `stable_q` XOR the value `pol_low` had at that edge.
- R12: While `en` is low, `stable_q` and `sense_q` hold, ticks have no effect, and `event_q` stays 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| en | input | 1 | Filter enable; a rising level re-arms from the raw sample |
| tick | input | 1 | One-cycle sampling strobe |
| raw_in | input | 1 | Synchronized raw pin level |
| pol_low | input | 1 | Active-low polarity: 1 makes the falling edge the active one and inverts `read_q` |
| dual_edge | input | 1 | 1 makes both accepted directions raise an event |
| stable_q | output | 1 | Debounced stable level |
| read_q | output | 1 | Polarity-corrected stable level |
| event_q | output | 1 | One-cycle accepted-edge event |
| sense_q | output | 1 | Edge-sense flag, inverted on each acceptance |

## Verification
The case that is hardest to reach from the ports is a run of disagreeing ticks that is broken partway. The count must be seen to restart, not merely to pause. The stimulus samples the opposite level on one tick, then the agreeing level on one tick, then the opposite level again. It checks that the stable level has not moved after the second disagreeing tick, although a total of two disagreeing ticks has been seen. Idle cycles without a tick are placed inside runs to show that they neither advance nor break the count. The enable is also dropped while the raw level disagrees, to show that nothing is accepted and that re-enabling reloads from the raw sample.

// File: rtl/dbn_pkg.sv
package dbn_pkg;

  typedef enum logic {
    DBN_IDLE = 1'b0,
    DBN_RUN  = 1'b1
  } dbn_state_e;

  function automatic int dbn_max(input int a, input int b);
    return (a > b) ? a : b;
  endfunction

endpackage

// File: rtl/dbn_run_counter.sv
module dbn_run_counter #(
  parameter int CNT_W = 2
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             load,
  input  logic [CNT_W-1:0] load_val,
  input  logic             dec,
  output logic             last
);

  logic [CNT_W-1:0] cnt_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt_q <= '0;
    end else if (load) begin
      cnt_q <= load_val;
    end else if (dec && (cnt_q != '0)) begin
      cnt_q <= cnt_q - 1'b1;
    end
  end

  // A disagreeing tick that finds one step left ends the run.
  assign last = (cnt_q == CNT_W'(1));

endmodule

// File: rtl/dbn_event_gate.sv
module dbn_event_gate (
  input  logic accept,
  input  logic new_level,
  input  logic pol_low,
  input  logic dual_edge,
  output logic fire
);

  logic active_dir;

  // The active direction is the one that lands on the asserted level.
  assign active_dir = new_level ^ pol_low;
  assign fire       = accept & (dual_edge | active_dir);

endmodule

// File: rtl/pin_debounce_filter.sv
module pin_debounce_filter
  import dbn_pkg::*;
#(
  parameter int RISE_TICKS = 2,
  parameter int FALL_TICKS = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic en,
  input  logic tick,
  input  logic raw_in,
  input  logic pol_low,
  input  logic dual_edge,
  output logic stable_q,
  output logic read_q,
  output logic event_q,
  output logic sense_q
);

  localparam int MAX_TICKS = dbn_max(dbn_max(RISE_TICKS, FALL_TICKS), 1);
  localparam int CNT_W     = $clog2(MAX_TICKS + 1);
  localparam logic [CNT_W-1:0] RISE_C = CNT_W'(RISE_TICKS);
  localparam logic [CNT_W-1:0] FALL_C = CNT_W'(FALL_TICKS);

  dbn_state_e state_q;
  logic       arm, run_tick, agree, dec, last, accept, reload, fire;
  logic       stable_d, sense_d;
  logic [CNT_W-1:0] reload_val;

  assign arm      = en && (state_q == DBN_IDLE);
  assign run_tick = en && (state_q == DBN_RUN) && tick;
  assign agree    = (raw_in == stable_q);
  assign dec      = run_tick && !agree;
  assign accept   = dec && last;
  assign reload   = arm || (run_tick && agree) || accept;
  // In every reload case the level to be left next equals raw_in.
  assign reload_val = raw_in ? FALL_C : RISE_C;

  generate
    if (MAX_TICKS == 1) begin : g_single
      assign last = 1'b1;
    end else begin : g_count
      dbn_run_counter #(.CNT_W(CNT_W)) u_cnt (
        .clk      (clk),
        .rst      (rst),
        .load     (reload),
        .load_val (reload_val),
        .dec      (dec),
        .last     (last)
      );
    end
  endgenerate

  dbn_event_gate u_gate (
    .accept    (accept),
    .new_level (raw_in),
    .pol_low   (pol_low),
    .dual_edge (dual_edge),
    .fire      (fire)
  );

  always_comb begin
    stable_d = stable_q;
    sense_d  = sense_q;
    if (arm) begin
      stable_d = raw_in;
      sense_d  = raw_in;
    end else if (accept) begin
      stable_d = raw_in;
      sense_d  = ~sense_q;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q  <= DBN_IDLE;
      stable_q <= 1'b0;
      sense_q  <= 1'b0;
      read_q   <= 1'b0;
      event_q  <= 1'b0;
    end else begin
      state_q  <= en ? DBN_RUN : DBN_IDLE;
      stable_q <= stable_d;
      sense_q  <= sense_d;
      read_q   <= stable_d ^ pol_low;
      event_q  <= fire;
    end
  end

endmodule

// File: rtl/dbn_checker.sv
module dbn_checker (
  input logic clk,
  input logic rst,
  input logic en,
  input logic tick,
  input logic pol_low,
  input logic stable_q,
  input logic read_q,
  input logic event_q,
  input logic sense_q
);

  p_event_needs_tick_r9: assert property (@(posedge clk) disable iff (rst)
    event_q |-> ($past(tick) && $past(en)));

  p_disabled_quiet_r12: assert property (@(posedge clk) disable iff (rst)
    !en |=> (!event_q && $stable(stable_q) && $stable(sense_q)));

  p_read_tracks_r11: assert property (@(posedge clk) disable iff (rst)
    $past(!rst) |-> (read_q == (stable_q ^ $past(pol_low))));

  p_sense_flips_r10: assert property (@(posedge clk) disable iff (rst)
    event_q |-> (sense_q != $past(sense_q)));

  p_level_needs_enable_r4: assert property (@(posedge clk) disable iff (rst)
    ($past(!rst) && !$stable(stable_q)) |-> $past(en));

endmodule

bind pin_debounce_filter dbn_checker u_dbn_chk (
  .clk      (clk),
  .rst      (rst),
  .en       (en),
  .tick     (tick),
  .pol_low  (pol_low),
  .stable_q (stable_q),
  .read_q   (read_q),
  .event_q  (event_q),
  .sense_q  (sense_q)
);

// File: tb/sim_pin_debounce_filter.sv
`timescale 1ns/1ps
module sim_pin_debounce_filter;

  localparam int RISE_N = 2;
  localparam int FALL_N = 2;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic en = 1'b0, tick = 1'b0, raw_in = 1'b0, pol_low = 1'b0, dual_edge = 1'b0;
  logic stable_q, read_q, event_q, sense_q;

  int n_checks = 0;
  int n_fail   = 0;
  bit done     = 0;
  bit live     = 0;

  always #5 clk = ~clk;

  pin_debounce_filter #(.RISE_TICKS(RISE_N), .FALL_TICKS(FALL_N)) u0 (
    .clk(clk), .rst(rst), .en(en), .tick(tick), .raw_in(raw_in),
    .pol_low(pol_low), .dual_edge(dual_edge),
    .stable_q(stable_q), .read_q(read_q), .event_q(event_q), .sense_q(sense_q)
  );

  // Behavioural reference: one integer counter of disagreeing ticks.
  bit m_on, m_lvl, m_sense, m_ev, m_rd;
  int m_miss;

  always @(posedge clk) begin
    int need;
    if (rst) begin
      m_on = 0; m_lvl = 0; m_sense = 0; m_ev = 0; m_rd = 0; m_miss = 0;
    end else begin
      m_ev = 0;
      if (!en) begin
        m_on = 0;
      end else if (!m_on) begin
        m_on = 1; m_lvl = raw_in; m_sense = raw_in; m_miss = 0;
      end else if (tick) begin
        if (raw_in == m_lvl) begin
          m_miss = 0;
        end else begin
          m_miss++;
          need = m_lvl ? FALL_N : RISE_N;
          if (m_miss >= need) begin
            m_lvl = raw_in; m_miss = 0; m_sense = !m_sense;
            m_ev = dual_edge || (pol_low ? (raw_in == 0) : (raw_in == 1));
          end
        end
      end
      m_rd = m_lvl ^ pol_low;
    end
  end

  task automatic chk(input string req, input logic act, input logic exp);
    n_checks++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%b expected=%b at %0t", req, act, exp, $time);
    end
  endtask

  always @(negedge clk) begin
    if (live && !done) begin
      chk("R4 model stable_q", stable_q, m_lvl);
      chk("R11 model read_q", read_q, m_rd);
      chk("R9 model event_q", event_q, m_ev);
      chk("R10 model sense_q", sense_q, m_sense);
    end
  end

  task automatic cyc(input logic r, input logic t);
    raw_in = r; tick = t;
    @(negedge clk);
    tick = 1'b0;
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("[TB] %0d tests run, %0d failed", n_checks, n_fail);
      $finish;
    end
  endtask

  initial begin
    repeat (5000) @(posedge clk);
    n_checks++; n_fail++;
    $display("FAIL watchdog actual=timeout expected=completion");
    finish_run();
  end

  initial begin
    @(negedge clk); @(negedge clk); @(negedge clk);
    chk("R1 stable reset", stable_q, 1'b0);
    chk("R1 read reset", read_q, 1'b0);
    chk("R1 event reset", event_q, 1'b0);
    chk("R1 sense reset", sense_q, 1'b0);
    rst = 1'b0; live = 1;

    // R2: arm from a high raw level, no tick
    en = 1'b1; cyc(1'b1, 1'b0);
    chk("R2 arm stable", stable_q, 1'b1);
    chk("R2 arm sense", sense_q, 1'b1);
    chk("R2 arm no event", event_q, 1'b0);

    // R5/R6: fall accepted after two ticks, no event when active high
    cyc(1'b0, 1'b1);
    chk("R5 one tick holds", stable_q, 1'b1);
    cyc(1'b0, 1'b0);
    cyc(1'b0, 1'b1);
    chk("R5 fall accepted", stable_q, 1'b0);
    chk("R6 no event on fall", event_q, 1'b0);
    chk("R10 sense after fall", sense_q, 1'b0);

    // R3: broken run restarts the count
    cyc(1'b1, 1'b1);
    cyc(1'b0, 1'b1);
    cyc(1'b1, 1'b1);
    chk("R3 broken run holds", stable_q, 1'b0);
    cyc(1'b1, 1'b1);
    chk("R4 rise accepted", stable_q, 1'b1);
    chk("R6 event on rise", event_q, 1'b1);
    cyc(1'b1, 1'b0);
    chk("R9 event one cycle", event_q, 1'b0);

    // R11/R7: active-low polarity
    pol_low = 1'b1; cyc(1'b1, 1'b0);
    chk("R11 read inverted", read_q, 1'b0);
    cyc(1'b0, 1'b1); cyc(1'b0, 1'b1);
    chk("R7 event on fall", event_q, 1'b1);
    chk("R11 read after fall", read_q, 1'b1);
    cyc(1'b1, 1'b1); cyc(1'b1, 1'b1);
    chk("R7 no event on rise", event_q, 1'b0);

    // R8: dual-edge
    dual_edge = 1'b1; pol_low = 1'b0;
    cyc(1'b0, 1'b1); cyc(1'b0, 1'b1);
    chk("R8 event on fall", event_q, 1'b1);
    cyc(1'b1, 1'b1); cyc(1'b1, 1'b1);
    chk("R8 event on rise", event_q, 1'b1);
    dual_edge = 1'b0;

    // R12: disabled, ticks ignored
    en = 1'b0;
    for (int i = 0; i < 4; i++) begin
      cyc(1'b0, 1'b1);
      chk("R12 disabled no event", event_q, 1'b0);
    end
    chk("R12 disabled holds", stable_q, 1'b1);

    // R2: re-enable takes the raw level
    en = 1'b1; cyc(1'b0, 1'b1);
    chk("R2 rearm stable", stable_q, 1'b0);
    chk("R2 rearm no event", event_q, 1'b0);

    // Fast back-to-back ticks
    for (int i = 0; i < 6; i++) cyc(i[1], 1'b1);
    repeat (3) cyc(1'b0, 1'b0);
    finish_run();
  end

endmodule